// File: doc/BRIEF.md
# AUX Request Status Monitor

This block sits behind the auxiliary-channel decoder of a display-link receiver and keeps a status record of the requests that the decoder finds. The decoder supplies single-cycle strobes for the start of a request, its end, each detected error and each edge seen during the SYNC preamble. It also supplies the parsed command, address and length fields, which are valid in the cycle of the end strobe. Software reads the record through a small word-indexed register port. The same port has one write action, which clears the counters.

A three-state machine follows each request. `ST_IDLE` waits for a start strobe and moves to `ST_WAIT_SYNC`. `ST_WAIT_SYNC` waits for the first SYNC edge and then moves to `ST_MEASURE`. `ST_MEASURE` stays where it is on later SYNC edges and times the spacing between them. An end strobe moves either active state back to `ST_IDLE`. That transition also publishes the command, address, length and half-period together and counts the request.

Top module: `aux_req_monitor`

## Requirements
- R1: Register index 0 bit 0 (busy) reads 0 after reset. It reads 1 from the clock edge that samples `req_start` while idle, and returns to 0 at the edge that samples `req_end`.
- R2: Register index 2 holds an 8-bit count of completed requests, meaning `req_end` samples taken while busy. It resets to 0 and saturates at 255.
- R3: Register index 1 holds a 4-bit count of clock cycles in which `req_err` is high. It resets to 0 and saturates at 15.
- R4: A write to register index 2 clears the request count and the error count. The clear takes priority over an increment in the same cycle.
- R5: Register index 3 holds the number of clock cycles between the last two consecutive `sync_edge` samples of the most recent completed request, clamped to 1023. A request with fewer than two SYNC edges reports 0.
- R6: Register indices 4 (command, 4 bits), 5 (address, 20 bits) and 6 (length, 4 bits) change only at a completed request's end and are all updated together.
- R7: When the command's bit 3 is 0 (an I2C-over-AUX request), the stored address keeps only bits 6:0 and bits 19:7 read 0. When bit 3 is 1, all 20 bits are stored.
- R8: The stored length is the byte count minus one, as given on `req_len`. When `req_addr_only` is high, the stored length is 0.
- R9: Writes to any index other than 2 have no effect, and index 7 reads 0.
- R10: `req_start` while busy is ignored and does not end the busy period. `req_end` while idle is ignored and is not counted.
- R11: All register fields read 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_start | input | 1 | Request start strobe from the decoder |
| req_end | input | 1 | Request end strobe; field inputs are valid in this cycle |
| req_err | input | 1 | Error detected on the inbound request |
| sync_edge | input | 1 | One pulse per edge seen during the SYNC preamble |
| req_cmd | input | 4 | Parsed command field |
| req_addr | input | 20 | Parsed address field |
| req_len | input | 4 | Parsed length field, byte count minus one |
| req_addr_only | input | 1 | Request carries no data bytes |
| reg_addr | input | 3 | Register word index |
| reg_wr | input | 1 | Register write strobe |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |

## Verification
A vector table drives complete requests with different commands, SYNC edge spacings and edge counts. Native and I2C commands check whether the address is masked. Address-only and data requests check the length rule. A single-edge request and a 1100-cycle spacing check the zero result and the clamp. Directed sequences then run enough requests and errors to reach saturation, and a clear is made to coincide with an increment. Stray start and end strobes, and writes to other indices, check that the ignored inputs leave the registers unchanged.

// File: rtl/aux_mon_pkg.sv
package aux_mon_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_WAIT_SYNC = 2'd1,
        ST_MEASURE   = 2'd2
    } mon_state_t;

    localparam int IDX_BUSY    = 0;
    localparam int IDX_ERR_CNT = 1;
    localparam int IDX_REQ_CNT = 2;
    localparam int IDX_HALF    = 3;
    localparam int IDX_CMD     = 4;
    localparam int IDX_ADDR    = 5;
    localparam int IDX_LEN     = 6;

endpackage

// File: rtl/aux_mon_fsm.sv
module aux_mon_fsm
    import aux_mon_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_start,
    input  logic req_end,
    input  logic sync_edge,
    output logic busy,
    output logic armed,
    output logic begin_req,
    output logic finish_req
);

    mon_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (req_start) state_d = ST_WAIT_SYNC;
            ST_WAIT_SYNC: if (req_end)   state_d = ST_IDLE;
                          else if (sync_edge) state_d = ST_MEASURE;
            ST_MEASURE:   if (req_end)   state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        busy       = (state_q != ST_IDLE);
        armed      = (state_q == ST_MEASURE);
        begin_req  = (state_q == ST_IDLE) && req_start;
        finish_req = (state_q != ST_IDLE) && req_end;
    end

endmodule

// File: rtl/aux_mon_sat_cnt.sv
module aux_mon_sat_cnt #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [WIDTH-1:0] count
);

    localparam logic [WIDTH-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (!rst_n || clr)          count <= '0;
        else if (inc && count != TOP) count <= count + 1'b1;
    end

endmodule

// File: rtl/aux_mon_halfper.sv
module aux_mon_halfper #(
    parameter int HALF_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              begin_req,
    input  logic              busy,
    input  logic              armed,
    input  logic              sync_edge,
    output logic [HALF_W-1:0] interval
);

    localparam logic [HALF_W-1:0] CLAMP = '1;
    localparam logic [HALF_W-1:0] ONE   = HALF_W'(1);

    logic [HALF_W-1:0] run_q;

    always_ff @(posedge clk) begin
        if (!rst_n || begin_req) begin
            run_q    <= '0;
            interval <= '0;
        end else if (busy && sync_edge) begin
            if (armed) interval <= run_q;
            run_q <= ONE;
        end else if (armed && run_q != CLAMP) begin
            run_q <= run_q + 1'b1;
        end
    end

endmodule

// File: rtl/aux_req_monitor.sv
module aux_req_monitor
    import aux_mon_pkg::*;
#(
    parameter int CMD_W     = 4,
    parameter int ADDR_W    = 20,
    parameter int I2C_W     = 7,
    parameter int LEN_W     = 4,
    parameter int REQ_CNT_W = 8,
    parameter int ERR_CNT_W = 4,
    parameter int HALF_W    = 10,
    parameter int RIDX_W    = 3,
    parameter int DATA_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_start,
    input  logic              req_end,
    input  logic              req_err,
    input  logic              sync_edge,
    input  logic [CMD_W-1:0]  req_cmd,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              req_addr_only,
    input  logic [RIDX_W-1:0] reg_addr,
    input  logic              reg_wr,
    output logic [DATA_W-1:0] reg_rdata
);

    localparam logic [ADDR_W-1:0] I2C_MASK = ADDR_W'((1 << I2C_W) - 1);

    logic                 busy, armed, begin_req, finish_req, clr;
    logic [REQ_CNT_W-1:0] req_cnt;
    logic [ERR_CNT_W-1:0] err_cnt;
    logic [HALF_W-1:0]    interval;
    logic [HALF_W-1:0]    half_q;
    logic [CMD_W-1:0]     cmd_q;
    logic [ADDR_W-1:0]    addr_q;
    logic [LEN_W-1:0]     len_q;

    assign clr = reg_wr && (reg_addr == RIDX_W'(IDX_REQ_CNT));

    aux_mon_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_start  (req_start),
        .req_end    (req_end),
        .sync_edge  (sync_edge),
        .busy       (busy),
        .armed      (armed),
        .begin_req  (begin_req),
        .finish_req (finish_req)
    );

    aux_mon_sat_cnt #(.WIDTH(REQ_CNT_W)) u_req_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .inc   (finish_req),
        .count (req_cnt)
    );

    aux_mon_sat_cnt #(.WIDTH(ERR_CNT_W)) u_err_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .inc   (req_err),
        .count (err_cnt)
    );

    aux_mon_halfper #(.HALF_W(HALF_W)) u_halfper (
        .clk       (clk),
        .rst_n     (rst_n),
        .begin_req (begin_req),
        .busy      (busy),
        .armed     (armed),
        .sync_edge (sync_edge),
        .interval  (interval)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= '0;
            addr_q <= '0;
            len_q  <= '0;
            half_q <= '0;
        end else if (finish_req) begin
            cmd_q  <= req_cmd;
            addr_q <= req_cmd[CMD_W-1] ? req_addr : (req_addr & I2C_MASK);
            len_q  <= req_addr_only ? '0 : req_len;
            half_q <= interval;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (int'(reg_addr))
            IDX_BUSY:    reg_rdata[0]           = busy;
            IDX_ERR_CNT: reg_rdata[ERR_CNT_W-1:0] = err_cnt;
            IDX_REQ_CNT: reg_rdata[REQ_CNT_W-1:0] = req_cnt;
            IDX_HALF:    reg_rdata[HALF_W-1:0]  = half_q;
            IDX_CMD:     reg_rdata[CMD_W-1:0]   = cmd_q;
            IDX_ADDR:    reg_rdata[ADDR_W-1:0]  = addr_q;
            IDX_LEN:     reg_rdata[LEN_W-1:0]   = len_q;
            default:     reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/aux_req_monitor_chk.sv
module aux_req_monitor_chk
    import aux_mon_pkg::*;
#(
    parameter int CMD_W     = 4,
    parameter int ADDR_W    = 20,
    parameter int I2C_W     = 7,
    parameter int LEN_W     = 4,
    parameter int REQ_CNT_W = 8,
    parameter int ERR_CNT_W = 4,
    parameter int RIDX_W    = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_start,
    input logic                 req_end,
    input logic                 reg_wr,
    input logic [RIDX_W-1:0]    reg_addr,
    input logic                 busy,
    input logic [REQ_CNT_W-1:0] req_cnt,
    input logic [ERR_CNT_W-1:0] err_cnt,
    input logic [CMD_W-1:0]     cmd_q,
    input logic [ADDR_W-1:0]    addr_q,
    input logic [LEN_W-1:0]     len_q
);

    logic wipe;
    assign wipe = reg_wr && (reg_addr == RIDX_W'(IDX_REQ_CNT));

    AST_BUSY_RISES: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_start) |=> busy); // R1
    AST_BUSY_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req_end) |=> !busy); // R1
    AST_REQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req_end && !wipe && req_cnt != '1) |=> req_cnt == $past(req_cnt) + 1'b1); // R2
    AST_IDLE_END_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !wipe) |=> $stable(req_cnt)); // R10
    AST_ERR_HOLD_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (err_cnt == '1 && !wipe) |=> err_cnt == '1); // R3
    AST_CLEAR_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        wipe |=> (req_cnt == '0 && err_cnt == '0)); // R4
    AST_FIELDS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && req_end) |=> ($stable(cmd_q) && $stable(addr_q) && $stable(len_q))); // R6
    AST_I2C_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_q[CMD_W-1] |-> (addr_q >> I2C_W) == '0); // R7

endmodule

bind aux_req_monitor aux_req_monitor_chk #(
    .CMD_W     (CMD_W),
    .ADDR_W    (ADDR_W),
    .I2C_W     (I2C_W),
    .LEN_W     (LEN_W),
    .REQ_CNT_W (REQ_CNT_W),
    .ERR_CNT_W (ERR_CNT_W),
    .RIDX_W    (RIDX_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_start (req_start),
    .req_end   (req_end),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .busy      (busy),
    .req_cnt   (req_cnt),
    .err_cnt   (err_cnt),
    .cmd_q     (cmd_q),
    .addr_q    (addr_q),
    .len_q     (len_q)
);

// File: tb/aux_req_monitor_test.sv
`timescale 1ns/1ps
module aux_req_monitor_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_start = 0, req_end = 0, req_err = 0, sync_edge = 0;
    logic [3:0]  req_cmd = 0;
    logic [19:0] req_addr = 0;
    logic [3:0]  req_len = 0;
    logic        req_addr_only = 0;
    logic [2:0]  reg_addr = 0;
    logic        reg_wr = 0;
    logic [31:0] reg_rdata;

    int n_run = 0;
    int n_fail = 0;
    int exp_req = 0;
    bit done = 0;

    always #4 clk = ~clk;

    aux_req_monitor uut (
        .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_end(req_end),
        .req_err(req_err), .sync_edge(sync_edge), .req_cmd(req_cmd),
        .req_addr(req_addr), .req_len(req_len), .req_addr_only(req_addr_only),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rdata(reg_rdata)
    );

    typedef struct packed {
        logic [3:0]  cmd;
        logic [19:0] addr;
        logic [3:0]  len;
        logic        aonly;
        logic [11:0] gap;
        logic [3:0]  edges;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{cmd:4'h9, addr:20'hABCDE, len:4'h7, aonly:1'b0, gap:12'd5,    edges:4'd4},
        '{cmd:4'h1, addr:20'hFFFFF, len:4'h3, aonly:1'b0, gap:12'd9,    edges:4'd3},
        '{cmd:4'h8, addr:20'h12345, len:4'hF, aonly:1'b1, gap:12'd2,    edges:4'd2},
        '{cmd:4'h5, addr:20'h00080, len:4'h0, aonly:1'b0, gap:12'd17,   edges:4'd1},
        '{cmd:4'hA, addr:20'h80001, len:4'hF, aonly:1'b0, gap:12'd1100, edges:4'd2},
        '{cmd:4'h0, addr:20'h7F07F, len:4'h1, aonly:1'b1, gap:12'd3,    edges:4'd5}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic rd(input int idx, output logic [31:0] d);
        @(negedge clk);
        reg_addr = 3'(idx);
        #1 d = reg_rdata;
    endtask

    task automatic wr(input int idx);
        @(negedge clk);
        reg_addr = 3'(idx);
        reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic run_req(input vec_t v);
        @(negedge clk); req_start = 1'b1;
        @(negedge clk); req_start = 1'b0;
        for (int i = 0; i < int'(v.edges); i++) begin
            if (i > 0) repeat (int'(v.gap) - 1) @(negedge clk);
            sync_edge = 1'b1;
            @(negedge clk); sync_edge = 1'b0;
        end
        req_cmd = v.cmd; req_addr = v.addr; req_len = v.len; req_addr_only = v.aonly;
        req_end = 1'b1;
        @(negedge clk); req_end = 1'b0;
        exp_req = (exp_req < 255) ? exp_req + 1 : 255;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] d;
        int exp_half, exp_addr, exp_len;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11: reset values of every index
        for (int k = 0; k < 8; k++) begin
            rd(k, d); check("R11 reset", d, 0);
        end

        // Vector table: R5 R6 R7 R8 R2
        foreach (VEC[i]) begin
            run_req(VEC[i]);
            exp_half = (VEC[i].edges < 2) ? 0 : ((VEC[i].gap > 1023) ? 1023 : int'(VEC[i].gap));
            exp_addr = VEC[i].cmd[3] ? int'(VEC[i].addr) : int'(VEC[i].addr & 20'h7F);
            exp_len  = VEC[i].aonly ? 0 : int'(VEC[i].len);
            rd(3, d); check("R5 half period", d, exp_half);
            rd(4, d); check("R6 command", d, VEC[i].cmd);
            rd(5, d); check("R7 address", d, exp_addr);
            rd(6, d); check("R8 length", d, exp_len);
            rd(2, d); check("R2 request count", d, exp_req);
            rd(0, d); check("R1 idle after end", d, 0);
        end

        // R1 busy during a request; R10 stray start ignored
        @(negedge clk); req_start = 1'b1;
        @(negedge clk); req_start = 1'b0;
        rd(0, d); check("R1 busy", d, 1);
        @(negedge clk); req_start = 1'b1;
        @(negedge clk); req_start = 1'b0;
        rd(0, d); check("R10 start while busy", d, 1);
        req_cmd = 4'hC; req_addr = 20'h00011; req_len = 4'h2; req_addr_only = 1'b0;
        // R6: fields not yet published while busy
        rd(4, d); check("R6 hold until end", d, VEC[5].cmd);
        @(negedge clk); req_end = 1'b1;
        @(negedge clk); req_end = 1'b0;
        exp_req++;
        rd(2, d); check("R10 one count per request", d, exp_req);
        rd(4, d); check("R6 command published", d, 4'hC);

        // R10 end while idle ignored
        @(negedge clk); req_cmd = 4'h3; req_end = 1'b1;
        @(negedge clk); req_end = 1'b0;
        rd(2, d); check("R10 idle end count", d, exp_req);
        rd(4, d); check("R10 idle end fields", d, 4'hC);

        // R3 error saturation
        @(negedge clk); req_err = 1'b1;
        repeat (20) @(negedge clk);
        req_err = 1'b0;
        rd(1, d); check("R3 error saturates", d, 15);

        // R9 writes elsewhere ignored; index 7 reads 0
        wr(1); wr(3); wr(0);
        rd(1, d); check("R9 err kept", d, 15);
        rd(2, d); check("R9 req kept", d, exp_req);
        rd(7, d); check("R9 unused index", d, 0);

        // R4 clear both
        wr(2);
        rd(2, d); check("R4 req cleared", d, 0);
        rd(1, d); check("R4 err cleared", d, 0);
        exp_req = 0;

        // R2 saturation at 255
        for (int k = 0; k < 260; k++) begin
            @(negedge clk); req_start = 1'b1;
            @(negedge clk); req_start = 1'b0; req_end = 1'b1;
            @(negedge clk); req_end = 1'b0;
        end
        rd(2, d); check("R2 saturates", d, 255);

        // R4 clear beats simultaneous increment
        @(negedge clk); req_start = 1'b1;
        @(negedge clk); req_start = 1'b0;
        req_end = 1'b1; req_err = 1'b1; reg_wr = 1'b1; reg_addr = 3'd2;
        @(negedge clk); req_end = 1'b0; req_err = 1'b0; reg_wr = 1'b0;
        rd(2, d); check("R4 clear wins req", d, 0);
        rd(1, d); check("R4 clear wins err", d, 0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule